// File: doc/BRIEF.md
# Pixel-Counted Conversion Mode Controller

This block holds the mode register that steers a colour-format conversion pass into a frame memory. It also holds the two image size registers that set how long that pass lasts. Software reaches all three through a small word-wide register port. Writing a conversion mode into an idle controller loads a down-counter with the X size times the Y size. The conversion datapath then strobes once for every pixel it finishes.

When the last pixel is counted, the controller returns itself to normal mode and raises a one-clock done pulse. While a conversion is running, CPU requests to the frame memory are refused. The mode bits and the pixel counter have no reset, so an in-flight pass resumes after a reset. The size registers clear on reset. The colour arithmetic is not part of this block: it sees only the mode output and drives the pixel strobe.

Top module: `conv_mode_ctrl`

## Requirements
- R1: Register address 0 holds the mode in bits 1:0, with these codes: 00 = normal (no conversion), 01 = YUV-to-RGB, 10 = delta-YUV-to-RGB. A write takes effect on the clock edge that samples it. The mode is readable at address 0 and drives mode_o.
- R2: A write of mode code 11 is ignored, and the previous mode is kept.
- R3: Bits 15:2 at address 0 always read as zero, whatever value was written to them.
- R4: Address 1 holds the X size and address 2 holds the Y size. Each keeps the low 10 bits of the written data and reads back zero-extended to 16 bits. Address 3 reads as zero.
- R5: Writing a nonzero legal mode while the mode is 00 loads the pixel count with X*Y. The mode then returns to 00 on the clock edge that samples the X*Y-th pixel strobe.
- R6: done_o is high for exactly one clock, in the cycle right after the final strobe is sampled, and mode_o reads 00 in that same cycle.
- R7: A pixel strobe while the mode is 00 is ignored: no done pulse occurs and the mode does not change.
- R8: fm_grant_o follows fm_req_i while the mode is 00 and is low while a conversion mode is active. conv_active_o is high exactly when the mode is nonzero.
- R9: rst_ni low keeps the mode bits and the remaining pixel count. It clears the X and Y size registers and done_o.
- R10: Starting a conversion with X*Y equal to zero ends it on the next clock edge with a done pulse, even if no pixel strobe arrives.
- R11: Writing mode 00 during a conversion stops it at once and produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pix_i | input | 1 | One pixel processed by the conversion datapath |
| mode_o | output | 2 | Current conversion mode |
| conv_active_o | output | 1 | A conversion mode is active |
| done_o | output | 1 | One-clock pulse when a pass completes |
| fm_req_i | input | 1 | CPU request to the frame memory |
| fm_grant_o | output | 1 | Gated CPU frame-memory request |

## Verification
The mode flops have no reset, so the assertions stay inactive until software has written a legal mode after the last reset. The stimulus therefore writes the mode register before any conversion is checked. Changing the mode to a different nonzero code mid-pass has no defined outcome. The assertions therefore assume that writes during a pass carry only 00 or the ignored code 11. They also assume that no such write arrives on the same edge as the final strobe, and the stimulus follows both rules. Pixel strobes are also sent while the controller is idle, to show that they are ignored.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_YUV    = 2'b01,
    MODE_DYUV   = 2'b10,
    MODE_BAD    = 2'b11
  } mode_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_XSIZE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_YSIZE = 2'd2;
endpackage

// File: rtl/cmr_size_reg.sv
module cmr_size_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/cmr_pix_cnt.sv
// Remaining-pixel counter; deliberately unreset so a pass survives reset.
module cmr_pix_cnt #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (load_i)     cnt_q <= load_val_i;
    else if (dec_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cmr_mode_ctl.sv
module cmr_mode_ctl
  import cmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_mode_i,
  input  logic [1:0] wmode_i,
  input  logic       pix_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_last_i,
  output mode_e      mode_o,
  output logic       start_o,
  output logic       dec_o,
  output logic       done_o
);
  mode_e mode_q;
  logic  legal_wr, active, expire;

  assign legal_wr = wr_mode_i && (mode_e'(wmode_i) != MODE_BAD);
  assign active   = (mode_q != MODE_NORMAL);
  assign start_o  = legal_wr && !active && (mode_e'(wmode_i) != MODE_NORMAL);
  assign dec_o    = active && pix_i && !cnt_zero_i;
  assign expire   = active && (cnt_zero_i || (pix_i && cnt_last_i));

  // Mode bits hold through reset; a legal write outranks expiry.
  always_ff @(posedge clk_i) begin
    if (legal_wr)    mode_q <= mode_e'(wmode_i);
    else if (expire) mode_q <= MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= expire && !legal_wr;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
  import cmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned X_W    = 10,
  parameter int unsigned Y_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pix_i,
  output logic [1:0]        mode_o,
  output logic              conv_active_o,
  output logic              done_o,
  input  logic              fm_req_i,
  output logic              fm_grant_o
);
  localparam int unsigned CNT_W = X_W + Y_W;

  logic [X_W-1:0]   x_q;
  logic [Y_W-1:0]   y_q;
  logic [CNT_W-1:0] total;
  logic             start, dec, cnt_zero, cnt_last;
  mode_e            mode;

  cmr_size_reg #(.W(X_W)) u_xsize (
    .clk_i, .rst_ni,
    .we_i (wr_i && addr_i == ADDR_XSIZE),
    .d_i  (wdata_i[X_W-1:0]),
    .q_o  (x_q)
  );

  cmr_size_reg #(.W(Y_W)) u_ysize (
    .clk_i, .rst_ni,
    .we_i (wr_i && addr_i == ADDR_YSIZE),
    .d_i  (wdata_i[Y_W-1:0]),
    .q_o  (y_q)
  );

  assign total = CNT_W'(x_q) * CNT_W'(y_q);

  cmr_pix_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i,
    .load_i     (start),
    .load_val_i (total),
    .dec_i      (dec),
    .zero_o     (cnt_zero),
    .last_o     (cnt_last)
  );

  cmr_mode_ctl u_ctl (
    .clk_i, .rst_ni,
    .wr_mode_i  (wr_i && addr_i == ADDR_MODE),
    .wmode_i    (wdata_i[1:0]),
    .pix_i,
    .cnt_zero_i (cnt_zero),
    .cnt_last_i (cnt_last),
    .mode_o     (mode),
    .start_o    (start),
    .dec_o      (dec),
    .done_o
  );

  assign mode_o        = mode;
  assign conv_active_o = (mode != MODE_NORMAL);
  assign fm_grant_o    = fm_req_i && (mode == MODE_NORMAL);

  always_comb begin
    unique case (addr_i)
      ADDR_MODE:  rdata_o = {{(DATA_W-2){1'b0}}, mode};
      ADDR_XSIZE: rdata_o = {{(DATA_W-X_W){1'b0}}, x_q};
      ADDR_YSIZE: rdata_o = {{(DATA_W-Y_W){1'b0}}, y_q};
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/conv_mode_ctrl_chk.sv
module conv_mode_ctrl_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              pix_i,
  input logic [1:0]        mode_o,
  input logic              conv_active_o,
  input logic              done_o,
  input logic              fm_req_i,
  input logic              fm_grant_o
);
  // Mode flops are unreset; arm once software has written a legal mode.
  logic armed_q;
  logic wr_mode;
  assign wr_mode = wr_i && (addr_i == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (wr_mode && wdata_i[1:0] != 2'b11) armed_q <= 1'b1;
  end

  p_mode_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (wr_mode && wdata_i[1:0] != 2'b11) |=> (mode_o == $past(wdata_i[1:0])));

  p_bad_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (wr_mode && wdata_i[1:0] == 2'b11 && mode_o == 2'b00) |=> (mode_o == 2'b00));

  p_never_bad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    mode_o != 2'b11);

  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[DATA_W-1:2] == '0));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    done_o |=> !done_o);

  p_done_normal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    done_o |-> (mode_o == 2'b00));

  p_idle_no_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (mode_o == 2'b00) |=> !done_o);

  p_grant_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (mode_o != 2'b00) |-> (!fm_grant_o && conv_active_o));

  p_grant_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (mode_o == 2'b00) |-> (fm_grant_o == fm_req_i && !conv_active_o));

  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (wr_mode && wdata_i[1:0] == 2'b00) |=> (!done_o && mode_o == 2'b00));
endmodule

bind conv_mode_ctrl conv_mode_ctrl_chk u_chk (.*);

// File: tb/tb_conv_mode_ctrl.sv
`timescale 1ns/1ps
module tb_conv_mode_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        pix_i = 1'b0;
  logic [1:0]  mode_o;
  logic        conv_active_o, done_o;
  logic        fm_req_i = 1'b0;
  logic        fm_grant_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  conv_mode_ctrl dut (.*);

  typedef struct packed {
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h0003, 16'h0003, "R4"},
    '{2'd2, 16'h0002, 16'h0002, "R4"},
    '{2'd1, 16'hFC05, 16'h0005, "R4"},
    '{2'd2, 16'hFFFF, 16'h03FF, "R4"},
    '{2'd0, 16'h0000, 16'h0000, "R1"},
    '{2'd0, 16'h0002, 16'h0002, "R1"},
    '{2'd0, 16'h0003, 16'h0002, "R2"},
    '{2'd0, 16'h0000, 16'h0000, "R11"},
    '{2'd0, 16'hFFFD, 16'h0001, "R3"},
    '{2'd0, 16'hFFFC, 16'h0000, "R3"},
    '{2'd0, 16'h0003, 16'h0000, "R2"}
  };

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic strobe();
    pix_i = 1'b1; tick(); pix_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R9: size registers and done cleared by reset
    rd(2'd1, r); chk("R9 xsize reset", r, 0);
    rd(2'd2, r); chk("R9 ysize reset", r, 0);
    chk("R9 done reset", done_o, 0);
    rd(2'd3, r); chk("R4 unused addr", r, 0);

    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i].addr, VEC[i].wdata);
      rd(VEC[i].addr, r);
      chk($sformatf("%s vec%0d", VEC[i].tag, i), r, VEC[i].exp);
    end

    // R7: strobes while idle do nothing
    fm_req_i = 1'b1;
    #1 chk("R8 grant idle", fm_grant_o, 1);
    for (int i = 0; i < 4; i++) begin
      strobe();
      chk("R7 idle done", done_o, 0);
      chk("R7 idle mode", mode_o, 0);
    end

    // R5/R6: 3x2 pass, six strobes
    bus_wr(2'd1, 16'd3);
    bus_wr(2'd2, 16'd2);
    bus_wr(2'd0, 16'h0001);
    chk("R1 mode out", mode_o, 1);
    chk("R8 grant blocked", fm_grant_o, 0);
    chk("R8 active", conv_active_o, 1);
    for (int i = 0; i < 5; i++) begin
      strobe();
      chk("R5 mode held", mode_o, 1);
      chk("R6 no early done", done_o, 0);
    end
    tick();
    chk("R5 gap keeps mode", mode_o, 1);
    strobe();
    chk("R5 mode cleared", mode_o, 0);
    chk("R6 done pulse", done_o, 1);
    chk("R8 grant restored", fm_grant_o, 1);
    tick();
    chk("R6 done one cycle", done_o, 0);

    // R10: zero product ends next edge
    bus_wr(2'd1, 16'd0);
    bus_wr(2'd0, 16'h0002);
    chk("R10 entered", mode_o, 2);
    tick();
    chk("R10 mode cleared", mode_o, 0);
    chk("R10 done", done_o, 1);
    tick();
    chk("R10 done one cycle", done_o, 0);

    // R11: abort mid pass
    bus_wr(2'd1, 16'd4);
    bus_wr(2'd2, 16'd1);
    bus_wr(2'd0, 16'h0001);
    strobe(); strobe();
    bus_wr(2'd0, 16'h0000);
    chk("R11 aborted", mode_o, 0);
    chk("R11 no done", done_o, 0);
    strobe(); strobe();
    chk("R11 no late done", done_o, 0);

    // R9: mode and count survive reset
    bus_wr(2'd1, 16'd2);
    bus_wr(2'd2, 16'd2);
    bus_wr(2'd0, 16'h0002);
    strobe();
    rst_ni = 1'b0; tick(); tick(); rst_ni = 1'b1; tick();
    rd(2'd0, r); chk("R9 mode kept", r, 2);
    rd(2'd1, r); chk("R9 xsize cleared", r, 0);
    strobe(); strobe();
    chk("R9 count kept", mode_o, 2);
    strobe();
    chk("R9 resumed end", mode_o, 0);
    chk("R9 resumed done", done_o, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule